// File: doc/BRIEF.md
# Multi-Channel Clock Frequency Meter

This block measures up to eight clock-like inputs against a reference. Software programs a clock-group choice, a reference choice, a measurement window length and a 2-bit mode per channel through a small word-addressed register bus. It then writes a start command and polls a busy flag. When busy clears, each channel's count register holds one of two values. In frequency mode it is the number of rising edges seen on that channel during the window. In timer mode it is the number of timing-clock edges that elapsed before the channel's first rising edge.

All monitored inputs pass through two-flop synchronizers into the system clock domain, so every measured signal must toggle slower than half the system clock. The window starts at the first rising edge of the selected reference after the start command. It closes after the programmed number of further reference edges. A stop command ends a window early. Timer-mode channels can count a fast alternate clock instead of the reference. One synchronized channel input can be routed to a monitor pin.

Top module: `clk_freq_meter`

## Requirements
- R1: After reset every register word reads zero, busy reads 0 and the monitor output is 0.
- R2: Registers sit at word indices 0 (control), 1 (clock select), 2 (window length), 3 (mode) and 4+n (count of channel n). Indices 12 to 15 read zero and ignore writes. The clock-select fields are group at bits 2:0, reference pick at bit 4 (0 = reference A, 1 = reference B), fast-timing pick at bit 5, monitor channel at bits 10:8 and monitor enable at bit 11. Other bits read zero. The window length keeps only its low 24 bits, and the mode register is 16 bits.
- R3: Writing control bit 0 = 1 (with bit 1 = 0) while idle starts a measurement, and control bit 0 reads 1 until it completes. Writes to the window-length and mode registers are ignored while busy.
- R4: The window opens at the first synchronized rising edge of the selected reference after start. It closes on the N-th reference rising edge after that, where N is the window length.
- R5: The group field selects which set of channel inputs is measured. A group index beyond the implemented groups gives constant-low inputs.
- R6: Channel n's mode is bits 2n+1:2n of the mode register, coded 00 off, 01 frequency, 10 reserved, 11 timer. Off and reserved channels read zero after a start.
- R7: A frequency-mode channel counts the rising edges of its input that fall after the opening edge, up to and including the closing edge.
- R8: A timer-mode channel counts timing edges (the reference, or the fast clock when bit 5 is set) until its first input rising edge inside the window. That edge and any later ones are not counted, and it counts to the window end if no edge comes.
- R9: Writing control bit 1 = 1 during a measurement clears busy and keeps the partial counts unchanged afterwards.
- R10: A start with window length zero leaves busy at 0 and all counts at zero.
- R11: Counters stop at their all-ones value instead of wrapping.
- R12: Every start clears all channel counts before counting begins.
- R13: When enabled, the monitor output follows the synchronized input of the selected channel. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word index of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from bus_addr_i |
| chan_clk_i | input | N_GRP*N_CH | Channel inputs, group g at bits g*N_CH upward |
| ref_a_i | input | 1 | Reference A |
| ref_b_i | input | 1 | Reference B |
| fast_clk_i | input | 1 | Alternate timing clock for timer mode |
| mon_o | output | 1 | Monitor output |

## Verification
Register reads are combinational and are sampled one delta after the address is set. Busy is due from the edge that captures the start write, and is gone from the edge that captures a stop or zero-length start. Because of the synchronizer depth, the window opens about three cycles after a raw reference edge, so the bench derives every test clock from one cycle counter. It issues each start at a fixed counter phase, which puts the opening edge and every channel edge at a known offset. The bench reads counts only after polling busy low. Monitor checks count rising transitions over 32 cycles, a multiple of every test period, so the result does not depend on phase.

// File: rtl/fm_pkg.sv
package fm_pkg;
   typedef enum logic [1:0] {
      MD_OFF   = 2'b00,
      MD_FREQ  = 2'b01,
      MD_RSVD  = 2'b10,
      MD_TIMER = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_ARM  = 2'd1,
      WS_RUN  = 2'd2
   } wstate_e;

   localparam int unsigned MAX_CH = 8;
   localparam int unsigned MAX_GRP = 8;
   localparam logic [3:0] W_CTRL = 4'd0;
   localparam logic [3:0] W_CSEL = 4'd1;
   localparam logic [3:0] W_RUNT = 4'd2;
   localparam logic [3:0] W_MODE = 4'd3;
   localparam logic [3:0] W_CNT0 = 4'd4;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
   parameter int unsigned W = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] lvl_o,
   output logic [W-1:0] rise_o
);
   generate
      if (W < 1) begin : g_bad_w
         $error("fm_sync: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] meta_q, sync_q, prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         meta_q <= '0;
         sync_q <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= raw_i;
         sync_q <= meta_q;
         prev_q <= sync_q;
      end
   end

   assign lvl_o  = sync_q;
   assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/fm_window.sv
module fm_window
   import fm_pkg::*;
#(
   parameter int unsigned RUN_W = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [RUN_W-1:0] runtime_i,
   input  logic             tick_i,
   output logic             busy_o,
   output logic             run_o,
   output logic             clr_o
);
   wstate_e          state_q;
   logic [RUN_W-1:0] remain_q;

   assign busy_o = (state_q != WS_IDLE);
   assign run_o  = (state_q == WS_RUN);
   assign clr_o  = start_i && (state_q == WS_IDLE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q  <= WS_IDLE;
         remain_q <= '0;
      end else begin
         case (state_q)
            WS_IDLE: begin
               if (start_i && (runtime_i != '0)) state_q <= WS_ARM;
            end
            WS_ARM: begin
               if (stop_i) begin
                  state_q <= WS_IDLE;
               end else if (tick_i) begin
                  remain_q <= runtime_i;
                  state_q  <= WS_RUN;
               end
            end
            WS_RUN: begin
               if (stop_i) begin
                  state_q <= WS_IDLE;
               end else if (tick_i) begin
                  if (remain_q == RUN_W'(1)) state_q <= WS_IDLE;
                  else remain_q <= remain_q - 1'b1;
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   // R3: an accepted start with a non-zero window raises busy
   a_r3_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o && runtime_i != '0) |=> busy_o);
   // R3: busy holds while neither a stop nor a reference edge arrives
   a_r3_busy_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !stop_i && !tick_i) |=> busy_o);
   // R10: a zero-length window never raises busy
   a_r10_zero_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o && runtime_i == '0) |=> !busy_o);
   // R9: a stop ends the measurement on the next edge
   a_r9_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && stop_i) |=> !busy_o);
   // R4: the remaining-edge count stays within the programmed window
   a_r4_remain_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_o |-> (remain_q != '0 && remain_q <= runtime_i));
endmodule

// File: rtl/fm_channel.sv
module fm_channel
   import fm_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             run_i,
   input  mode_e            mode_i,
   input  logic             edge_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic frozen_q;
   logic at_max;

   assign at_max = (cnt_o == CNT_MAX);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o    <= '0;
         frozen_q <= 1'b0;
      end else if (clr_i) begin
         cnt_o    <= '0;
         frozen_q <= 1'b0;
      end else if (run_i) begin
         case (mode_i)
            MD_FREQ: begin
               if (edge_i && !at_max) cnt_o <= cnt_o + 1'b1;
            end
            MD_TIMER: begin
               if (!frozen_q) begin
                  if (edge_i) frozen_q <= 1'b1;
                  else if (tick_i && !at_max) cnt_o <= cnt_o + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // R11: a saturated counter stays saturated until cleared
   a_r11_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (at_max && !clr_i) |=> (cnt_o == CNT_MAX));
   // R6: off and reserved channels never move away from their value
   a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && (mode_i == MD_OFF || mode_i == MD_RSVD)) |=> $stable(cnt_o));
   // R8: a timer channel is frozen after its first input edge
   a_r8_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && frozen_q) |=> $stable(cnt_o));
   // R12: a start clears the count
   a_r12_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_o == '0));
   // R7: counts advance by at most one per cycle
   a_r7_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
   import fm_pkg::*;
#(
   parameter int unsigned N_CH  = 8,
   parameter int unsigned N_GRP = 2,
   parameter int unsigned CNT_W = 32,
   parameter int unsigned RUN_W = 24
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   bus_en_i,
   input  logic                   bus_we_i,
   input  logic [3:0]             bus_addr_i,
   input  logic [31:0]            bus_wdata_i,
   output logic [31:0]            bus_rdata_o,
   input  logic [N_GRP*N_CH-1:0]  chan_clk_i,
   input  logic                   ref_a_i,
   input  logic                   ref_b_i,
   input  logic                   fast_clk_i,
   output logic                   mon_o
);
   localparam int unsigned MODE_W = 2 * N_CH;
   localparam int unsigned SYNC_W = N_CH + 3;
   localparam int unsigned IX_REFA = N_CH;
   localparam int unsigned IX_REFB = N_CH + 1;
   localparam int unsigned IX_FAST = N_CH + 2;

   generate
      if (N_CH < 1 || N_CH > MAX_CH) begin : g_bad_ch
         $error("clk_freq_meter: N_CH must be 1..8");
      end
      if (N_GRP < 1 || N_GRP > MAX_GRP) begin : g_bad_grp
         $error("clk_freq_meter: N_GRP must be 1..8");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("clk_freq_meter: CNT_W must be 1..32");
      end
      if (RUN_W < 1 || RUN_W > 32) begin : g_bad_run
         $error("clk_freq_meter: RUN_W must be 1..32");
      end
   endgenerate

   // register state
   logic [2:0]        grp_sel_q;
   logic              ref_sel_q;
   logic              fast_sel_q;
   logic [2:0]        mon_sel_q;
   logic              mon_en_q;
   logic [RUN_W-1:0]  runtime_q;
   logic [MODE_W-1:0] mode_q;

   logic busy, run, clr;
   logic wr, start_p, stop_p;

   assign wr      = bus_en_i && bus_we_i;
   assign stop_p  = wr && (bus_addr_i == W_CTRL) && bus_wdata_i[1];
   assign start_p = wr && (bus_addr_i == W_CTRL) && bus_wdata_i[0] && !bus_wdata_i[1] && !busy;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         grp_sel_q  <= '0;
         ref_sel_q  <= 1'b0;
         fast_sel_q <= 1'b0;
         mon_sel_q  <= '0;
         mon_en_q   <= 1'b0;
         runtime_q  <= '0;
         mode_q     <= '0;
      end else if (wr) begin
         if (bus_addr_i == W_CSEL) begin
            grp_sel_q  <= bus_wdata_i[2:0];
            ref_sel_q  <= bus_wdata_i[4];
            fast_sel_q <= bus_wdata_i[5];
            mon_sel_q  <= bus_wdata_i[10:8];
            mon_en_q   <= bus_wdata_i[11];
         end
         if (bus_addr_i == W_RUNT && !busy) runtime_q <= bus_wdata_i[RUN_W-1:0];
         if (bus_addr_i == W_MODE && !busy) mode_q    <= bus_wdata_i[MODE_W-1:0];
      end
   end

   // input group multiplexer
   logic [N_CH-1:0] raw_ch;
   always_comb begin
      raw_ch = '0;
      for (int g = 0; g < N_GRP; g++) begin
         if (grp_sel_q == 3'(g)) raw_ch = chan_clk_i[g*N_CH +: N_CH];
      end
   end

   logic [SYNC_W-1:0] lvl, rise;

   fm_sync #(.W(SYNC_W)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  ({fast_clk_i, ref_b_i, ref_a_i, raw_ch}),
      .lvl_o  (lvl),
      .rise_o (rise)
   );

   logic ref_tick, time_tick;
   assign ref_tick  = ref_sel_q  ? rise[IX_REFB] : rise[IX_REFA];
   assign time_tick = fast_sel_q ? rise[IX_FAST] : ref_tick;

   fm_window #(.RUN_W(RUN_W)) u_window (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_i   (start_p),
      .stop_i    (stop_p),
      .runtime_i (runtime_q),
      .tick_i    (ref_tick),
      .busy_o    (busy),
      .run_o     (run),
      .clr_o     (clr)
   );

   logic [CNT_W-1:0] cnt [N_CH];

   generate
      for (genvar i = 0; i < N_CH; i++) begin : g_ch
         fm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clr_i  (clr),
            .run_i  (run),
            .mode_i (mode_e'(mode_q[2*i +: 2])),
            .edge_i (rise[i]),
            .tick_i (time_tick),
            .cnt_o  (cnt[i])
         );
      end
   endgenerate

   // monitor output
   always_comb begin
      mon_o = 1'b0;
      for (int i = 0; i < N_CH; i++) begin
         if (mon_en_q && mon_sel_q == 3'(i)) mon_o = lvl[i];
      end
   end

   // read multiplexer
   always_comb begin
      bus_rdata_o = '0;
      case (bus_addr_i)
         W_CTRL: bus_rdata_o[0] = busy;
         W_CSEL: begin
            bus_rdata_o[2:0]  = grp_sel_q;
            bus_rdata_o[4]    = ref_sel_q;
            bus_rdata_o[5]    = fast_sel_q;
            bus_rdata_o[10:8] = mon_sel_q;
            bus_rdata_o[11]   = mon_en_q;
         end
         W_RUNT: bus_rdata_o[RUN_W-1:0]  = runtime_q;
         W_MODE: bus_rdata_o[MODE_W-1:0] = mode_q;
         default: begin
            for (int i = 0; i < N_CH; i++) begin
               if (bus_addr_i == W_CNT0 + 4'(i)) bus_rdata_o[CNT_W-1:0] = cnt[i];
            end
         end
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{bus_wdata_i, lvl[SYNC_W-1:N_CH]};

   // R3: the programmed window length cannot change during a measurement
   a_r3_runtime_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |=> $stable(runtime_q));
   // R3: the mode register cannot change during a measurement
   a_r3_mode_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy |=> $stable(mode_q));
endmodule

// File: tb/clk_freq_meter_bench.sv
module clk_freq_meter_bench;
   localparam int N_CH  = 8;
   localparam int N_GRP = 2;
   localparam int CNT_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0, we = 1'b0;
   logic [3:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [N_GRP*N_CH-1:0] chan = '0;
   logic ref_a = 1'b0, ref_b = 1'b0, fast = 1'b0;
   logic mon;

   int k = 0;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   // all test clocks derive from one cycle counter
   always @(negedge clk) begin
      k = k + 1;
      ref_a = k[2];
      ref_b = k[3];
      fast  = k[0];
      for (int i = 0; i < N_CH; i++) begin
         chan[i]        = k[i % 4];
         chan[N_CH + i] = k[3 - (i % 4)];
      end
   end

   clk_freq_meter #(.N_CH(N_CH), .N_GRP(N_GRP), .CNT_W(CNT_W), .RUN_W(24)) u_clk_freq_meter (
      .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .chan_clk_i(chan),
      .ref_a_i(ref_a), .ref_b_i(ref_b), .fast_clk_i(fast), .mon_o(mon));

   // {group[3], ref_b[1], fast[1], window[24], mode[16], expected ch7..ch0 [8 each]}
   localparam int NV = 7;
   localparam logic [108:0] VEC [NV] = '{
      {3'd0, 1'b0, 1'b0, 24'd4,  16'h5555, 64'h0204_0810_0204_0810},
      {3'd1, 1'b1, 1'b0, 24'd3,  16'h5555, 64'h180C_0603_180C_0603},
      {3'd0, 1'b0, 1'b0, 24'd4,  16'h7FE4, 64'h0200_0000_0100_0800},
      {3'd0, 1'b0, 1'b1, 24'd4,  16'h7FE4, 64'h0204_0100_0600_0800},
      {3'd7, 1'b0, 1'b0, 24'd5,  16'hFFFF, 64'h0505_0505_0505_0505},
      {3'd7, 1'b0, 1'b1, 24'd5,  16'hFFFF, 64'h1414_1414_1414_1414},
      {3'd0, 1'b1, 1'b0, 24'd40, 16'h5555, 64'h2850_A0FF_2850_A0FF}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); #1;
      en = 1'b1; we = 1'b1; addr = a; wdata = d;
      @(negedge clk); #1;
      en = 1'b0; we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); #1;
      addr = a;
      #1 d = rdata;
   endtask

   task automatic start_aligned();
      do begin
         @(negedge clk); #1;
      end while (k % 16 != 8);
      en = 1'b1; we = 1'b1; addr = 4'd0; wdata = 32'h1;
      @(negedge clk); #1;
      en = 1'b0; we = 1'b0; wdata = '0;
   endtask

   task automatic wait_idle();
      logic [31:0] d;
      for (int n = 0; n < 4000; n++) begin
         rd(4'd0, d);
         if (d[0] == 1'b0) return;
      end
   endtask

   task automatic count_mon_rises(output int rises);
      logic prev;
      rises = 0;
      @(negedge clk); #1;
      prev = mon;
      for (int n = 0; n < 32; n++) begin
         @(negedge clk); #1;
         if (mon && !prev) rises++;
         prev = mon;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] d, d2;
      int r;
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 16; a++) begin
         rd(4'(a), d);
         chk($sformatf("R1 reset word %0d", a), d, 32'h0);
      end
      chk("R1 reset monitor", {31'h0, mon}, 32'h0);

      // R2: field masks and reserved words
      wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, d); chk("R2 clock select mask", d, 32'h0000_0F37);
      wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, d); chk("R2 window mask", d, 32'h00FF_FFFF);
      wr(4'd3, 32'hFFFF_FFFF); rd(4'd3, d); chk("R2 mode mask", d, 32'h0000_FFFF);
      wr(4'd12, 32'hFFFF_FFFF); rd(4'd12, d); chk("R2 reserved word 12", d, 32'h0);
      wr(4'd15, 32'hA5A5_A5A5); rd(4'd15, d); chk("R2 reserved word 15", d, 32'h0);

      // R4 R5 R6 R7 R8 R11 R12: vector table
      for (int v = 0; v < NV; v++) begin
         logic [108:0] row;
         logic [31:0] csel;
         row = VEC[v];
         csel = '0;
         csel[2:0] = row[108:106];
         csel[4]   = row[105];
         csel[5]   = row[104];
         wr(4'd1, csel);
         wr(4'd2, {8'h0, row[103:80]});
         wr(4'd3, {16'h0, row[79:64]});
         start_aligned();
         rd(4'd0, d);
         chk($sformatf("R3 busy after start vector %0d", v), {31'h0, d[0]}, 32'h1);
         wait_idle();
         for (int c = 0; c < N_CH; c++) begin
            rd(4'(4 + c), d);
            chk($sformatf("R4 R5 R6 R7 R8 R11 R12 vector %0d channel %0d", v, c),
                d, {24'h0, row[8*c +: 8]});
         end
      end

      // R3 and R9: frozen registers while busy, then stop keeps partial counts
      wr(4'd1, 32'h0);
      wr(4'd2, 32'd100);
      wr(4'd3, 32'h5555);
      start_aligned();
      wr(4'd2, 32'd7);
      rd(4'd2, d); chk("R3 window write ignored while busy", d, 32'd100);
      wr(4'd3, 32'h0);
      rd(4'd3, d); chk("R3 mode write ignored while busy", d, 32'h5555);
      repeat (100) @(negedge clk);
      wr(4'd0, 32'h2);
      rd(4'd0, d); chk("R9 busy cleared by stop", {31'h0, d[0]}, 32'h0);
      rd(4'd7, d);
      checks++;
      if (d == 0 || d >= 50) begin
         errors++;
         $display("FAIL R9 partial count actual=%0d expected=1..49", d);
      end
      repeat (40) @(negedge clk);
      rd(4'd7, d2); chk("R9 partial count held", d2, d);

      // R10: zero-length window
      wr(4'd2, 32'd0);
      wr(4'd0, 32'h1);
      rd(4'd0, d); chk("R10 busy stays low", {31'h0, d[0]}, 32'h0);
      rd(4'd7, d); chk("R10 count cleared", d, 32'h0);
      rd(4'd4, d); chk("R10 channel 0 cleared", d, 32'h0);

      // R13: monitor output
      wr(4'd1, 32'h0000_0300);
      count_mon_rises(r); chk("R13 monitor disabled", r, 0);
      chk("R13 monitor disabled level", {31'h0, mon}, 32'h0);
      wr(4'd1, 32'h0000_0B00);
      count_mon_rises(r); chk("R13 monitor channel 3 period 16", r, 2);
      wr(4'd1, 32'h0000_0800);
      count_mon_rises(r); chk("R13 monitor channel 0 period 2", r, 16);
      wr(4'd1, 32'h0000_0901);
      count_mon_rises(r); chk("R13 R5 monitor group 1 channel 1 period 8", r, 4);
      wr(4'd1, 32'h0000_0807);
      count_mon_rises(r); chk("R13 R5 monitor unimplemented group", r, 0);

      finish_run();
   end
endmodule